// File: doc/BRIEF.md
# Eight-Pin GPIO Core with Change Interrupt

This block gives a host eight general-purpose pins behind a small register port. Each pin can be set as an input or an output. The host writes an output value latch and reads back the level actually present on every pin. An active-low interrupt line tells the host that an enabled pin has moved away from the level it saw at its last read of the pin state register.

The host reaches the block through a plain register port: an address, write data with a write strobe, and a read strobe whose data arrives on the next cycle. Pins leave the block as three vectors (sampled input, output value and output enable), so a pad ring or board model outside the block resolves the actual wire. A control register holds a self-clearing bit that returns the whole block to its reset state without using the hardware reset input.

Top module: `pinbank_top`

## Requirements
- R1: After hardware reset, `gpio_oe` and `gpio_o` are all zero, `irq_n` is 1, and reads of the direction (0xA), enable (0xC) and control (0xF) registers return 0.
- R2: The direction register sits at address 0xA. A bit at 1 makes that pin an output. `gpio_oe` equals the register from the cycle after the write, and a read returns the written value.
- R3: A write to the pin state register (address 0xB) loads the output latch. `gpio_o` shows the latch only on bits whose direction is output, so bits for input pins never reach the pins.
- R4: A read of address 0xB returns, one cycle after the read strobe, the synchronized level of all eight pins, whatever each pin's direction. A pin level needs two clock edges to reach this value.
- R5: The interrupt enable register sits at address 0xC, with one bit per pin. A pin whose enable bit is 0 never pulls `irq_n` low.
- R6: When a synchronized pin with its enable bit set differs from the reference level latched at the last state read, `irq_n` goes low on the next edge.
- R7: `irq_n` stays low until a read of address 0xB, even if the pin returns to its reference level. That read reloads the reference with the value it returns and releases `irq_n` on the same edge.
- R8: A change that reaches the synchronizer output in the same cycle as a state read appears in the read data and raises no interrupt. A change that arrives one cycle after the read raises the interrupt.
- R9: Writing a 1 to bit 3 of the control register (address 0xF) resets all registers, the reference and the pending interrupt on the following edge. Writing 0 to that bit has no effect. The bit always reads 0.
- R10: Writes to unmapped addresses change no register, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| gpio_i | input | 8 | Levels sampled from the pins |
| gpio_o | output | 8 | Output values, masked by direction |
| gpio_oe | output | 8 | Per-pin output enable |
| irq_n | output | 1 | Active-low change interrupt |

## Verification
Two events can land on the same edge: a host read of the pin state register, and a pin change that reaches the synchronizer output. The bench provokes this collision by changing a pin on a falling edge and then issuing the read either two edges later, so the read and the change coincide, or one edge later, so the change follows the read. It judges each case by the returned value and by whether `irq_n` falls afterwards. In the coinciding case the new level must be returned and no interrupt may follow. In the early case the old level must be returned and the interrupt must rise.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    parameter int PIN_W  = 8;
    parameter int ADDR_W = 4;
    parameter int SYNC_STAGES = 2;

    typedef logic [PIN_W-1:0]  pins_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_DIR   = addr_t'(4'hA);
    localparam addr_t A_STATE = addr_t'(4'hB);
    localparam addr_t A_IEN   = addr_t'(4'hC);
    localparam addr_t A_CTRL  = addr_t'(4'hF);
    localparam int    CTRL_SRST_BIT = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_STATE,
        SEL_IEN,
        SEL_CTRL
    } sel_e;

    typedef struct packed {
        pins_t dir;
        pins_t outv;
        pins_t ien;
    } cfg_t;

    function automatic sel_e decode(addr_t a);
        sel_e s;
        case (a)
            A_DIR:   s = SEL_DIR;
            A_STATE: s = SEL_STATE;
            A_IEN:   s = SEL_IEN;
            A_CTRL:  s = SEL_CTRL;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync
    import pinbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t d,
    output pins_t q
);
    logic [SYNC_STAGES-1:0][PIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign q = chain[SYNC_STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  blk_rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  addr_t addr,
    input  pins_t wdata,
    input  pins_t level,
    output cfg_t  cfg,
    output logic  srst_q,
    output logic  rd_state,
    output pins_t rdata
);
    sel_e  sel;
    pins_t rd_mux;

    assign sel      = decode(addr);
    assign rd_state = rd_en && (sel == SEL_STATE);

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:   cfg.dir  <= wdata;
                SEL_STATE: cfg.outv <= wdata;
                SEL_IEN:   cfg.ien  <= wdata;
                default:   ;
            endcase
        end
    end

    // self-clearing request; the block-wide reset follows one edge later
    always_ff @(posedge clk) begin
        if (rst) srst_q <= 1'b0;
        else     srst_q <= wr_en && (sel == SEL_CTRL) && wdata[CTRL_SRST_BIT];
    end

    always_comb begin
        case (sel)
            SEL_DIR:   rd_mux = cfg.dir;
            SEL_STATE: rd_mux = level;
            SEL_IEN:   rd_mux = cfg.ien;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (blk_rst)    rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
    import pinbank_pkg::*;
(
    input  logic  clk,
    input  logic  blk_rst,
    input  pins_t level,
    input  pins_t ien,
    input  logic  rd_state,
    output logic  irq_n
);
    pins_t ref_q;
    pins_t pend_q;

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (blk_rst) begin
                ref_q[i]  <= 1'b0;
                pend_q[i] <= 1'b0;
            end else if (rd_state) begin
                ref_q[i]  <= level[i];
                pend_q[i] <= 1'b0;
            end else if (ien[i] && (level[i] != ref_q[i])) begin
                pend_q[i] <= 1'b1;
            end
        end
    end

    assign irq_n = ~|pend_q;
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_W-1:0]  wdata,
    output logic [PIN_W-1:0]  rdata,
    input  logic [PIN_W-1:0]  gpio_i,
    output logic [PIN_W-1:0]  gpio_o,
    output logic [PIN_W-1:0]  gpio_oe,
    output logic              irq_n
);
    cfg_t  cfg_q;
    pins_t level;
    pins_t ien_w;
    logic  srst_q;
    logic  blk_rst;
    logic  rd_state;

    assign blk_rst = rst | srst_q;
    assign ien_w   = cfg_q.ien;

    pinbank_sync u_sync (
        .clk (clk),
        .rst (rst),
        .d   (gpio_i),
        .q   (level)
    );

    pinbank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .blk_rst  (blk_rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .level    (level),
        .cfg      (cfg_q),
        .srst_q   (srst_q),
        .rd_state (rd_state),
        .rdata    (rdata)
    );

    pinbank_irq u_irq (
        .clk      (clk),
        .blk_rst  (blk_rst),
        .level    (level),
        .ien      (ien_w),
        .rd_state (rd_state),
        .irq_n    (irq_n)
    );

    assign gpio_oe = cfg_q.dir;
    assign gpio_o  = cfg_q.outv & cfg_q.dir;
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  srst,
    input logic  wr_en,
    input logic  rd_en,
    input addr_t addr,
    input pins_t wdata,
    input pins_t gpio_o,
    input pins_t gpio_oe,
    input pins_t ien,
    input logic  irq_n
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (gpio_oe == '0 && gpio_o == '0 && irq_n));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DIR && !srst) |=> (gpio_oe == $past(wdata)));

    assert_out_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STATE && !srst) |=> (gpio_o == ($past(wdata) & gpio_oe)));

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> $past(|ien));

    assert_irq_release_on_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> ($past(rd_en && addr == A_STATE) || $past(srst)));

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTRL && wdata[CTRL_SRST_BIT] && !srst)
        |=> ##1 (gpio_oe == '0 && gpio_o == '0 && irq_n));
endmodule

bind pinbank_top pinbank_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .srst    (srst_q),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .gpio_o  (gpio_o),
    .gpio_oe (gpio_oe),
    .ien     (ien_w),
    .irq_n   (irq_n)
);

// File: tb/pinbank_tb.sv
module pinbank_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] gpio_i;
    logic [7:0] gpio_o;
    logic [7:0] gpio_oe;
    logic       irq_n;
    logic [7:0] ext = '0;
    int checks = 0;
    int fails  = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // board model: driven pins show the output value, others the external level
    assign gpio_i = (gpio_oe & gpio_o) | (~gpio_oe & ext);

    pinbank_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .gpio_i(gpio_i), .gpio_o(gpio_o),
        .gpio_oe(gpio_oe), .irq_n(irq_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick(4);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk(gpio_oe == 8'h00, "R1 oe", gpio_oe, 0);
        chk(gpio_o == 8'h00, "R1 out", gpio_o, 0);
        chk(irq_n == 1'b1, "R1 irq", irq_n, 1);
        rd(4'hA, v); chk(v == 8'h00, "R1 dir read", v, 0);
        rd(4'hC, v); chk(v == 8'h00, "R1 ien read", v, 0);
        rd(4'hF, v); chk(v == 8'h00, "R1 ctrl read", v, 0);

        // R10 unmapped addresses, R9 control write with bit 3 clear
        wr(4'hA, 8'h3C);
        wr(4'hD, 8'hFF);
        wr(4'h0, 8'hFF);
        rd(4'hD, v); chk(v == 8'h00, "R10 unmapped read", v, 0);
        rd(4'hA, v); chk(v == 8'h3C, "R10 dir kept", v, 8'h3C);
        rd(4'hC, v); chk(v == 8'h00, "R10 ien kept", v, 0);
        wr(4'hF, 8'hF7);
        tick(1);
        rd(4'hA, v); chk(v == 8'h3C, "R9 bit3 clear no reset", v, 8'h3C);

        // R2 R3 R4 sweep over every direction pattern
        for (int k = 0; k < 256; k++) begin
            logic [7:0] dv, ov, ex, pad;
            dv  = 8'(k);
            ov  = 8'(k * 29 + 7);
            ex  = ~dv ^ 8'h33;
            ext = ex;
            wr(4'hA, dv);
            wr(4'hB, ov);
            tick(3);
            pad = (dv & ov) | (~dv & ex);
            chk(gpio_oe == dv, "R2 oe", gpio_oe, dv);
            chk(gpio_o == (ov & dv), "R3 masked out", gpio_o, ov & dv);
            rd(4'hB, v); chk(v == pad, "R4 pin level", v, pad);
            if (k % 32 == 5) begin
                rd(4'hA, v); chk(v == dv, "R2 dir readback", v, dv);
            end
        end

        // R3 latch revealed when the pin turns to output
        wr(4'hA, 8'h00);
        wr(4'hB, 8'hA5);
        chk(gpio_o == 8'h00, "R3 input pins undriven", gpio_o, 0);
        wr(4'hA, 8'hFF);
        chk(gpio_o == 8'hA5, "R3 latch on output", gpio_o, 8'hA5);

        // R5 R6 R7 per pin
        wr(4'hA, 8'h00);
        ext = 8'h00;
        for (int i = 0; i < 8; i++) begin
            int j;
            j = (i + 3) % 8;
            wr(4'hC, 8'(1 << i));
            tick(3);
            rd(4'hB, v);
            tick(1);
            ext[j] = ~ext[j];
            tick(4);
            chk(irq_n == 1'b1, "R5 masked pin", irq_n, 1);
            ext[i] = ~ext[i];
            tick(4);
            chk(irq_n == 1'b0, "R6 enabled change", irq_n, 0);
            ext[i] = ~ext[i];
            tick(4);
            chk(irq_n == 1'b0, "R7 sticky", irq_n, 0);
            rd(4'hB, v);
            chk(v == ext, "R7 read value", v, ext);
            chk(irq_n == 1'b1, "R7 release", irq_n, 1);
        end

        // R8 read coinciding with a change
        wr(4'hC, 8'h01);
        ext = 8'h00;
        tick(3);
        rd(4'hB, v);
        tick(2);
        ext[0] = 1'b1;
        tick(2);
        rd(4'hB, v);
        chk(v[0] == 1'b1, "R8 same cycle value", v, v | 8'h01);
        for (int c = 0; c < 4; c++) begin
            tick(1);
            chk(irq_n == 1'b1, "R8 same cycle no irq", irq_n, 1);
        end
        // R8 change one cycle after the read
        ext[0] = 1'b0;
        tick(1);
        rd(4'hB, v);
        chk(v[0] == 1'b1, "R8 early read old value", v, v | 8'h01);
        tick(1);
        chk(irq_n == 1'b0, "R8 later change raises irq", irq_n, 0);
        rd(4'hB, v);
        chk(irq_n == 1'b1, "R8 cleared", irq_n, 1);

        // R9 soft reset
        wr(4'hA, 8'h0F);
        wr(4'hC, 8'hFF);
        wr(4'hB, 8'hAA);
        ext = ext ^ 8'hF0;
        tick(4);
        chk(irq_n == 1'b0, "R9 pre irq", irq_n, 0);
        wr(4'hF, 8'h08);
        chk(gpio_oe == 8'h0F, "R9 not before next edge", gpio_oe, 8'h0F);
        tick(1);
        chk(gpio_oe == 8'h00, "R9 oe", gpio_oe, 0);
        chk(gpio_o == 8'h00, "R9 out", gpio_o, 0);
        chk(irq_n == 1'b1, "R9 irq", irq_n, 1);
        rd(4'hA, v); chk(v == 8'h00, "R9 dir", v, 0);
        rd(4'hC, v); chk(v == 8'h00, "R9 ien", v, 0);
        rd(4'hF, v); chk(v == 8'h00, "R9 ctrl reads 0", v, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule